// File: doc/BRIEF.md
# Eight-Bit Accumulating ALU with Flags

This unit is the arithmetic and logic stage of a small register-based processor. The first operand is always a register, and that register also takes the result. The second operand is either another register or an 8-bit immediate carried in the instruction. One registered result bus comes out, together with a carry flag and a zero flag that the unit keeps itself. The current carry flag feeds the carry-using operations.

The operation groups are bitwise logic, add or subtract with an optional carry or borrow, and a one-place shift or rotate. A fourth path passes an input-port value straight to the result. Add, subtract and their carry variants share one adder. Every shift and rotate shares one shifter whose injected bit comes from a selectable source. A 4-way select picks the group result, and a single pipeline register follows it. The surrounding sequencer raises `exec_en` for one clock per executed instruction.

Top module: `byte_alu`

## Requirements
- R1: While `rst_n` is low, `result`, `carry_flag` and `zero_flag` are all 0.
- R2: Operand B is `imm_k` when `b_is_const` is 1 and `reg_b` when it is 0.
- R3: With `grp_sel`=00 (logic), `func_sel` 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B and 11 gives B unchanged. The carry flag is cleared.
- R4: With `grp_sel`=01, `func_sel` 00 (add) gives A+B and 01 (add with carry) gives A+B+carry. The carry flag takes bit 8 of the sum.
- R5: With `grp_sel`=01, `func_sel` 10 (subtract) gives A-B and 11 (subtract with borrow) gives A-B-carry, modulo 256. The carry flag is set exactly when a borrow occurs.
- R6: With `grp_sel`=10, register A moves one place: left when `shift_ctl[3]`=0 and right when it is 1. The bit that leaves (bit 7 on a left move, bit 0 on a right move) becomes the carry flag.
- R7: `shift_ctl[2:0]` picks the bit that enters the vacated position: 000 gives 0, 001 gives 1, 010 repeats the bit already at the filled end (bit 0 on left, bit 7 on right), 011 gives the current carry flag, 100 gives the bit leaving the opposite end (rotate), and 101 to 111 give 0.
- R8: Every logic, arithmetic or shift operation sets the zero flag to 1 exactly when the 8-bit result is 0.
- R9: With `grp_sel`=11 the result becomes `port_in`, and both flags keep their values.
- R10: While `exec_en` is 0, the result and both flags hold their values.
- R11: Outputs change at the clock edge that samples `exec_en`=1 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_en | input | 1 | Execute the presented operation at this edge |
| grp_sel | input | 2 | Group: 00 logic, 01 arithmetic, 10 shift, 11 port pass |
| func_sel | input | 2 | Operation within the logic or arithmetic group |
| shift_ctl | input | 4 | Bit 3 direction, bits 2:0 injected-bit source |
| b_is_const | input | 1 | Choose the immediate as operand B |
| reg_a | input | 8 | First operand register value |
| reg_b | input | 8 | Second operand register value |
| imm_k | input | 8 | Immediate constant from the instruction |
| port_in | input | 8 | Input-port value for the pass path |
| result | output | 8 | Registered result |
| carry_flag | output | 1 | Registered carry flag |
| zero_flag | output | 1 | Registered zero flag |

## Verification
The bound checker checks the following on every executed cycle:
- the zero flag agrees with the registered result;
- logic operations clear the carry;
- arithmetic carry matches the adder carry-out, inverted on subtracts;
- the shift carry matches the departing bit of A;
- the port pass keeps both flags;
- an idle cycle changes nothing.

The result values themselves can only be shown by the bench's scenarios. These cover each logic function, carry-in and borrow chaining on a carry flag prepared beforehand, every injected-bit source in both directions including the unused codes, the immediate operand select, and the one-cycle latency.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [1:0] {
    GRP_LOGIC = 2'b00,
    GRP_ARITH = 2'b01,
    GRP_SHIFT = 2'b10,
    GRP_PORT  = 2'b11
  } alu_grp_e;

  typedef enum logic [2:0] {
    INJ_ZERO   = 3'b000,
    INJ_ONE    = 3'b001,
    INJ_EDGE   = 3'b010,
    INJ_CARRY  = 3'b011,
    INJ_ROTATE = 3'b100
  } inj_src_e;

  // carry-in for the shared adder: subtracts use the inverted carry
  function automatic logic adder_cin(input logic [1:0] fn, input logic cflag);
    case (fn)
      2'b00:   adder_cin = 1'b0;
      2'b01:   adder_cin = cflag;
      2'b10:   adder_cin = 1'b1;
      default: adder_cin = ~cflag;
    endcase
  endfunction

endpackage

// File: rtl/byte_alu_logic.sv
module byte_alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,
  output logic [W-1:0] y
);
  always_comb begin
    case (fn)
      2'b00:   y = a & b;
      2'b01:   y = a | b;
      2'b10:   y = a ^ b;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/byte_alu_adder.sv
module byte_alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,
  input  logic         cflag,
  output logic [W-1:0] sum,
  output logic         cout
);
  import byte_alu_pkg::*;

  logic [W-1:0] b_eff;
  logic         cin;
  logic [W:0]   wide;

  assign b_eff = fn[1] ? ~b : b;
  assign cin   = adder_cin(fn, cflag);
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign sum   = wide[W-1:0];
  assign cout  = wide[W];
endmodule

// File: rtl/byte_alu_shifter.sv
module byte_alu_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [3:0]   ctl,
  input  logic         cflag,
  output logic [W-1:0] y,
  output logic         out_bit
);
  import byte_alu_pkg::*;

  logic go_right;
  logic inj;

  assign go_right = ctl[3];

  always_comb begin
    case (inj_src_e'(ctl[2:0]))
      INJ_ZERO:   inj = 1'b0;
      INJ_ONE:    inj = 1'b1;
      INJ_EDGE:   inj = go_right ? a[W-1] : a[0];
      INJ_CARRY:  inj = cflag;
      INJ_ROTATE: inj = go_right ? a[0] : a[W-1];
      default:    inj = 1'b0;
    endcase
  end

  assign y       = go_right ? {inj, a[W-1:1]} : {a[W-2:0], inj};
  assign out_bit = go_right ? a[0] : a[W-1];
endmodule

// File: rtl/byte_alu.sv
module byte_alu #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [1:0]        grp_sel,
  input  logic [1:0]        func_sel,
  input  logic [3:0]        shift_ctl,
  input  logic              b_is_const,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [DATA_W-1:0] imm_k,
  input  logic [DATA_W-1:0] port_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_flag,
  output logic              zero_flag
);
  import byte_alu_pkg::*;

  localparam int NGRP = 4;

  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] logic_y;
  logic [DATA_W-1:0] add_y;
  logic [DATA_W-1:0] shift_y;
  logic              add_cout;   // raw adder carry-out, observed by checker
  logic              shift_out;  // bit leaving the shifter
  logic [DATA_W-1:0] grp_y [NGRP];
  logic [DATA_W-1:0] sel_y;
  logic              carry_next;
  logic              flags_wr;

  assign opnd_b = b_is_const ? imm_k : reg_b;

  byte_alu_logic #(.W(DATA_W)) logic_i (
    .a(reg_a), .b(opnd_b), .fn(func_sel), .y(logic_y)
  );

  byte_alu_adder #(.W(DATA_W)) adder_i (
    .a(reg_a), .b(opnd_b), .fn(func_sel), .cflag(carry_flag),
    .sum(add_y), .cout(add_cout)
  );

  byte_alu_shifter #(.W(DATA_W)) shifter_i (
    .a(reg_a), .ctl(shift_ctl), .cflag(carry_flag),
    .y(shift_y), .out_bit(shift_out)
  );

  assign grp_y[GRP_LOGIC] = logic_y;
  assign grp_y[GRP_ARITH] = add_y;
  assign grp_y[GRP_SHIFT] = shift_y;
  assign grp_y[GRP_PORT]  = port_in;
  assign sel_y = grp_y[grp_sel];

  always_comb begin
    case (alu_grp_e'(grp_sel))
      GRP_LOGIC: carry_next = 1'b0;
      GRP_ARITH: carry_next = add_cout ^ func_sel[1];
      GRP_SHIFT: carry_next = shift_out;
      default:   carry_next = carry_flag;
    endcase
  end

  assign flags_wr = exec_en && (alu_grp_e'(grp_sel) != GRP_PORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      carry_flag <= 1'b0;
      zero_flag  <= 1'b0;
    end else begin
      if (exec_en) result <= sel_y;
      if (flags_wr) begin
        carry_flag <= carry_next;
        zero_flag  <= (sel_y == '0);
      end
    end
  end
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exec_en,
  input logic [1:0]        grp_sel,
  input logic [1:0]        func_sel,
  input logic [3:0]        shift_ctl,
  input logic [DATA_W-1:0] reg_a,
  input logic [DATA_W-1:0] port_in,
  input logic [DATA_W-1:0] result,
  input logic              carry_flag,
  input logic              zero_flag,
  input logic              add_cout
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (result == '0 && !carry_flag && !zero_flag)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> ($stable(result) && $stable(carry_flag) && $stable(zero_flag))); // R10

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && grp_sel != 2'b11) |=> (zero_flag == (result == '0))); // R8

  AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && grp_sel == 2'b00) |=> !carry_flag); // R3

  AST_ARITH_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && grp_sel == 2'b01) |=> (carry_flag == ($past(add_cout) ^ $past(func_sel[1])))); // R5

  AST_SHIFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && grp_sel == 2'b10) |=>
      (carry_flag == ($past(shift_ctl[3]) ? $past(reg_a[0]) : $past(reg_a[DATA_W-1])))); // R6

  AST_PORT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && grp_sel == 2'b11) |=>
      (result == $past(port_in) && $stable(carry_flag) && $stable(zero_flag))); // R9
endmodule

bind byte_alu byte_alu_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/byte_alu_tb_top.sv
`timescale 1ns/1ps
module byte_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_en = 1'b0;
  logic [1:0] grp_sel = '0;
  logic [1:0] func_sel = '0;
  logic [3:0] shift_ctl = '0;
  logic       b_is_const = 1'b0;
  logic [7:0] reg_a = '0, reg_b = '0, imm_k = '0, port_in = '0;
  logic [7:0] result;
  logic       carry_flag, zero_flag;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  byte_alu dut_i (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .grp_sel(grp_sel),
    .func_sel(func_sel), .shift_ctl(shift_ctl), .b_is_const(b_is_const),
    .reg_a(reg_a), .reg_b(reg_b), .imm_k(imm_k), .port_in(port_in),
    .result(result), .carry_flag(carry_flag), .zero_flag(zero_flag)
  );

  // {grp, func, shift_ctl, b_is_const, carry_before, a, b, k, exp_result, exp_carry, exp_zero}
  localparam int NV = 23;
  localparam logic [43:0] VEC [NV] = '{
    {2'd0,2'd0,4'h0,1'b0,1'b1,8'hF0,8'h3C,8'h00,8'h30,1'b0,1'b0}, // R3 and
    {2'd0,2'd1,4'h0,1'b1,1'b1,8'h0F,8'hFF,8'hA0,8'hAF,1'b0,1'b0}, // R3 R2 or imm
    {2'd0,2'd2,4'h0,1'b0,1'b0,8'h5A,8'h5A,8'h00,8'h00,1'b0,1'b1}, // R3 xor
    {2'd0,2'd3,4'h0,1'b1,1'b1,8'h77,8'h55,8'h00,8'h00,1'b0,1'b1}, // R3 R2 pass B
    {2'd1,2'd0,4'h0,1'b0,1'b0,8'hC8,8'h64,8'h00,8'h2C,1'b1,1'b0}, // R4 add
    {2'd1,2'd0,4'h0,1'b0,1'b1,8'h80,8'h80,8'h00,8'h00,1'b1,1'b1}, // R4 add wrap
    {2'd1,2'd1,4'h0,1'b0,1'b1,8'h0F,8'hF0,8'h00,8'h00,1'b1,1'b1}, // R4 addcy c=1
    {2'd1,2'd1,4'h0,1'b1,1'b0,8'hFE,8'h00,8'h01,8'hFF,1'b0,1'b0}, // R4 R2 addcy c=0
    {2'd1,2'd2,4'h0,1'b0,1'b1,8'h10,8'h01,8'h00,8'h0F,1'b0,1'b0}, // R5 sub
    {2'd1,2'd2,4'h0,1'b0,1'b0,8'h01,8'h02,8'h00,8'hFF,1'b1,1'b0}, // R5 sub borrow
    {2'd1,2'd3,4'h0,1'b0,1'b1,8'h05,8'h05,8'h00,8'hFF,1'b1,1'b0}, // R5 subcy c=1
    {2'd1,2'd3,4'h0,1'b0,1'b0,8'h05,8'h05,8'h00,8'h00,1'b0,1'b1}, // R5 subcy c=0
    {2'd2,2'd0,4'h0,1'b0,1'b0,8'h81,8'h00,8'h00,8'h02,1'b1,1'b0}, // R6 R7 left 0
    {2'd2,2'd0,4'h1,1'b0,1'b0,8'h40,8'h00,8'h00,8'h81,1'b0,1'b0}, // R7 left 1
    {2'd2,2'd0,4'h2,1'b0,1'b0,8'h03,8'h00,8'h00,8'h07,1'b0,1'b0}, // R7 left edge
    {2'd2,2'd0,4'h3,1'b0,1'b1,8'h00,8'h00,8'h00,8'h01,1'b0,1'b0}, // R7 left carry
    {2'd2,2'd0,4'h4,1'b0,1'b0,8'h80,8'h00,8'h00,8'h01,1'b1,1'b0}, // R7 left rotate
    {2'd2,2'd0,4'h8,1'b0,1'b0,8'h01,8'h00,8'h00,8'h00,1'b1,1'b1}, // R6 right 0
    {2'd2,2'd0,4'h9,1'b0,1'b0,8'h02,8'h00,8'h00,8'h81,1'b0,1'b0}, // R7 right 1
    {2'd2,2'd0,4'hA,1'b0,1'b0,8'h84,8'h00,8'h00,8'hC2,1'b0,1'b0}, // R7 right edge
    {2'd2,2'd0,4'hB,1'b0,1'b1,8'h01,8'h00,8'h00,8'h80,1'b1,1'b0}, // R7 right carry
    {2'd2,2'd0,4'hC,1'b0,1'b0,8'h01,8'h00,8'h00,8'h80,1'b1,1'b0}, // R7 right rotate
    {2'd2,2'd0,4'h7,1'b0,1'b1,8'h01,8'h00,8'h00,8'h02,1'b0,1'b0}  // R7 unused code
  };

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got res=%h c=%b z=%b expected res=%h c=%b z=%b",
               tag, act[9:2], act[1], act[0], exp[9:2], exp[1], exp[0]);
    end
  endtask

  task automatic drive(input logic [1:0] g, input logic [1:0] f, input logic [3:0] s,
                       input logic bc, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] k);
    grp_sel = g; func_sel = f; shift_ctl = s; b_is_const = bc;
    reg_a = a; reg_b = b; imm_k = k;
  endtask

  task automatic run_op(input logic [1:0] g, input logic [1:0] f, input logic [3:0] s,
                        input logic bc, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] k);
    @(negedge clk);
    drive(g, f, s, bc, a, b, k);
    exec_en = 1'b1;
    @(negedge clk);
    exec_en = 1'b0;
  endtask

  // FF + 01 gives carry 1 and result 0; FF + 00 gives carry 0
  task automatic set_carry(input logic c);
    run_op(2'd1, 2'd0, 4'h0, 1'b0, 8'hFF, c ? 8'h01 : 8'h00, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    check("R1 reset state", {result, carry_flag, zero_flag}, 10'h000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      set_carry(v[34]);
      run_op(v[43:42], v[41:40], v[39:36], v[35], v[33:26], v[25:18], v[17:10]);
      case (v[43:42])
        2'd0:    tag = "R3 R8";
        2'd1:    tag = v[41] ? "R5 R8" : "R4 R8";
        default: tag = "R6 R7 R8";
      endcase
      if (v[35]) tag = {tag, " R2"};
      check($sformatf("%s vec %0d", tag, i), {result, carry_flag, zero_flag}, v[9:0]);
    end

    // R9: port pass keeps flags (carry 1, zero 1 after set_carry(1))
    set_carry(1'b1);
    port_in = 8'h5A;
    run_op(2'd3, 2'd0, 4'h0, 1'b0, 8'h00, 8'h00, 8'h00);
    check("R9 port pass", {result, carry_flag, zero_flag}, {8'h5A, 1'b1, 1'b1});

    // R10: inputs change with exec_en low
    @(negedge clk);
    drive(2'd0, 2'd0, 4'h0, 1'b0, 8'h00, 8'h00, 8'h00);
    @(negedge clk);
    check("R10 idle hold", {result, carry_flag, zero_flag}, {8'h5A, 1'b1, 1'b1});

    // R11: no change before the edge, change at it
    drive(2'd0, 2'd2, 4'h0, 1'b0, 8'hFF, 8'h0F, 8'h00);
    exec_en = 1'b1;
    #1;
    check("R11 before edge", {result, carry_flag, zero_flag}, {8'h5A, 1'b1, 1'b1});
    @(negedge clk);
    exec_en = 1'b0;
    check("R11 after edge", {result, carry_flag, zero_flag}, {8'hF0, 1'b0, 1'b0});

    // R2: register B selected when b_is_const=0, immediate ignored
    run_op(2'd0, 2'd3, 4'h0, 1'b0, 8'h00, 8'h3C, 8'hC3);
    check("R2 reg select", {result, carry_flag, zero_flag}, {8'h3C, 1'b0, 1'b0});

    // R1: reset mid-run clears everything
    set_carry(1'b1);
    run_op(2'd0, 2'd3, 4'h0, 1'b1, 8'h00, 8'h00, 8'h99);
    set_carry(1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", {result, carry_flag, zero_flag}, 10'h000);
    @(negedge clk);
    rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule